// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the array address for each clock cycle of a pipelined synchronous memory. On a load cycle it captures an external address and the read/write type of the access. On each following advance cycle it steps a two-bit beat counter. The low two bits of the address it outputs follow either a wrapping linear sequence or an XOR-based interleaved sequence, chosen by a static order input. The upper address bits stay at their loaded value for the whole burst.

The block sits between the input registers and the memory array. The command inputs are a load/advance select, the chip-select result computed by the surrounding logic, and an active-high stall that freezes the block. A load while the chip is not selected ends the burst in progress. `beat_vld` then stays low until the next selected load. The array, the data path and byte masking belong to other blocks.

Top module: `burst_seq`

## Requirements
- R1: A clock edge with `stall`=0, `adv`=0 and `sel`=1 loads a burst. After that edge, `eff_addr` equals the sampled `ext_addr`, `beat_vld` is 1, and `burst_rd` equals the sampled `rw_rd` (1 = read, 0 = write).
- R2: With `order_il`=0 (linear order), beat k of a burst has low two address bits equal to (start low bits + k) mod 4. For example, a start of 2 gives 2, 3, 0, 1.
- R3: With `order_il`=1 (interleaved order), beat k has low two address bits equal to (start low bits) XOR k. For example, a start of 1 gives 1, 0, 3, 2.
- R4: Advancing past the fourth beat continues wrapping in the same order, so beat 4 repeats the start address.
- R5: `rw_rd` is ignored on advance cycles (`adv`=1). `burst_rd` keeps the value latched at the load.
- R6: `ext_addr` is ignored on advance cycles. Address bits above bit 1 stay at their loaded value for the whole burst.
- R7: A clock edge with `stall`=0, `adv`=0 and `sel`=0 ends any burst. `beat_vld` becomes 0 and stays 0 through later advance cycles until a selected load.
- R8: While `stall`=1, every other input is ignored. `eff_addr`, `beat_vld` and `burst_rd` hold their values, and the burst continues from the same beat afterwards.
- R9: While `rst_n` is 0, `eff_addr` is 0, `beat_vld` is 0 and `burst_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | AW | External start address |
| adv | input | 1 | 0 = load a new address, 1 = advance the beat counter |
| sel | input | 1 | Chip-select result, 1 = selected |
| stall | input | 1 | 1 = hold all state (clock enable inactive) |
| order_il | input | 1 | Static burst order: 0 = linear, 1 = interleaved |
| rw_rd | input | 1 | Access type at a load: 1 = read, 0 = write |
| eff_addr | output | AW | Array address for the current beat |
| burst_rd | output | 1 | Latched access type of the current burst |
| beat_vld | output | 1 | 1 while a burst is active |

## Verification
The bound checker tests the cycle-local rules on every clock:
- a load result equals the sampled address and type;
- a stall freezes all outputs;
- an advance keeps the type and the upper address bits;
- each linear step adds one to the low bits;
- each interleaved step from an even beat flips bit 0;
- a deselected load clears `beat_vld`.

Only the bench scenarios can show the full four-beat sequences and the repeat after the fourth beat. They also show that the burst resumes at the correct beat after a long stall, and that advance cycles after a deselect start nothing.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STEP = 2'd2,
    CMD_STOP = 2'd3
  } burst_cmd_e;

endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
  import burst_seq_pkg::*;
(
  input  logic       adv,
  input  logic       sel,
  input  logic       stall,
  input  logic       active,
  output burst_cmd_e cmd
);

  always_comb begin
    cmd = CMD_NONE;
    if (!stall) begin
      if (!adv) cmd = sel ? CMD_LOAD : CMD_STOP;
      else if (active) cmd = CMD_STEP;
    end
  end

endmodule

// File: rtl/burst_state.sv
module burst_state
  import burst_seq_pkg::*;
#(
  parameter int AW = 17,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  burst_cmd_e    cmd,
  input  logic [AW-1:0] ext_addr,
  input  logic          rw_rd,
  output logic [AW-1:0] base_addr,
  output logic [CW-1:0] beat_cnt,
  output logic          is_read,
  output logic          active
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      beat_cnt  <= '0;
      is_read   <= 1'b0;
      active    <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_LOAD: begin
          base_addr <= ext_addr;
          beat_cnt  <= '0;
          is_read   <= rw_rd;
          active    <= 1'b1;
        end
        CMD_STEP: beat_cnt <= beat_cnt + 1'b1;
        CMD_STOP: active   <= 1'b0;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 17,
  parameter int CW = 2
) (
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] beat_cnt,
  input  logic          order_il,
  output logic [AW-1:0] eff_addr
);

  function automatic logic [CW-1:0] lin_low(input logic [CW-1:0] s,
                                            input logic [CW-1:0] k);
    return s + k;
  endfunction

  function automatic logic [CW-1:0] il_low(input logic [CW-1:0] s,
                                           input logic [CW-1:0] k);
    return s ^ k;
  endfunction

  logic [CW-1:0] low_lin, low_il;

  assign low_lin  = lin_low(base_addr[CW-1:0], beat_cnt);
  assign low_il   = il_low(base_addr[CW-1:0], beat_cnt);
  assign eff_addr = {base_addr[AW-1:CW], order_il ? low_il : low_lin};

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int AW        = 17,
  parameter int BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          adv,
  input  logic          sel,
  input  logic          stall,
  input  logic          order_il,
  input  logic          rw_rd,
  output logic [AW-1:0] eff_addr,
  output logic          burst_rd,
  output logic          beat_vld
);

  localparam int CW = $clog2(BURST_LEN);

  burst_cmd_e    cmd;
  logic [AW-1:0] base_addr;
  logic [CW-1:0] beat_cnt;
  logic          active;

  burst_cmd_dec i_dec (
    .adv    (adv),
    .sel    (sel),
    .stall  (stall),
    .active (active),
    .cmd    (cmd)
  );

  burst_state #(.AW(AW), .CW(CW)) i_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .ext_addr  (ext_addr),
    .rw_rd     (rw_rd),
    .base_addr (base_addr),
    .beat_cnt  (beat_cnt),
    .is_read   (burst_rd),
    .active    (active)
  );

  burst_addr_gen #(.AW(AW), .CW(CW)) i_gen (
    .base_addr (base_addr),
    .beat_cnt  (beat_cnt),
    .order_il  (order_il),
    .eff_addr  (eff_addr)
  );

  assign beat_vld = active;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 17,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ext_addr,
  input logic          adv,
  input logic          sel,
  input logic          stall,
  input logic          order_il,
  input logic          rw_rd,
  input logic [AW-1:0] eff_addr,
  input logic          burst_rd,
  input logic          beat_vld,
  input logic [CW-1:0] beat_cnt
);

  // R1: a selected load presents the sampled address and type
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && sel) |=>
      (beat_vld && eff_addr == $past(ext_addr) && burst_rd == $past(rw_rd)));

  // R2: a linear step adds one to the low bits
  p_lin_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv && beat_vld && !order_il) |=>
      (eff_addr[1:0] == $past(eff_addr[1:0]) + 2'd1));

  // R3: an interleaved step from an even beat flips bit 0
  p_il_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv && beat_vld && order_il && !beat_cnt[0]) |=>
      (eff_addr[1:0] == ($past(eff_addr[1:0]) ^ 2'b01)));

  // R5: the type is kept while advancing
  p_type_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv) |=> $stable(burst_rd));

  // R6: the upper address bits are kept while advancing
  p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv) |=> $stable(eff_addr[AW-1:CW]));

  // R7: a deselected load ends the burst
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && !sel) |=> !beat_vld);

  // R8: a stall freezes the outputs
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(eff_addr) && $stable(beat_vld) && $stable(burst_rd)));

endmodule

bind burst_seq burst_seq_chk #(.AW(AW), .CW(CW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ext_addr (ext_addr),
  .adv      (adv),
  .sel      (sel),
  .stall    (stall),
  .order_il (order_il),
  .rw_rd    (rw_rd),
  .eff_addr (eff_addr),
  .burst_rd (burst_rd),
  .beat_vld (beat_vld),
  .beat_cnt (beat_cnt)
);

// File: tb/test_burst_seq.sv
`timescale 1ns/1ps
module test_burst_seq;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          adv = 1'b0, sel = 1'b0, stall = 1'b0, order_il = 1'b0, rw_rd = 1'b0;
  logic [AW-1:0] eff_addr;
  logic          burst_rd, beat_vld;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_seq #(.AW(AW), .BURST_LEN(4)) i_burst_seq (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .adv(adv), .sel(sel),
    .stall(stall), .order_il(order_il), .rw_rd(rw_rd),
    .eff_addr(eff_addr), .burst_rd(burst_rd), .beat_vld(beat_vld)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic s, input logic st,
                       input logic rw, input logic [AW-1:0] ad);
    adv = a; sel = s; stall = st; rw_rd = rw; ext_addr = ad;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Expected address of beat k, restated with integer arithmetic
  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] start,
                                              input int k, input bit il);
    int lo, kk;
    int res;
    lo = start % 4;
    kk = k % 4;
    if (il) begin
      res = 0;
      for (int b = 0; b < 2; b++)
        if (((lo >> b) & 1) != ((kk >> b) & 1)) res += (1 << b);
    end else begin
      res = (lo + kk) % 4;
    end
    return (start - start % 4) + AW'(res);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic t_reset();
    check("R9 eff_addr", 32'(eff_addr), 0);
    check("R9 beat_vld", 32'(beat_vld), 0);
    check("R9 burst_rd", 32'(burst_rd), 0);
  endtask

  task automatic t_burst(input logic [AW-1:0] start, input bit il, input logic rd);
    order_il = il;
    drive(1'b0, 1'b1, 1'b0, rd, start);
    tick();
    check("R1 load addr", 32'(eff_addr), 32'(start));
    check("R1 load vld", 32'(beat_vld), 1);
    check("R1 load type", 32'(burst_rd), 32'(rd));
    for (int k = 1; k <= 6; k++) begin
      drive(1'b1, 1'b0, 1'b0, ~rd, ~start);
      tick();
      if (il) check("R3 interleaved beat", 32'(eff_addr), 32'(beat_addr(start, k, 1'b1)));
      else    check("R2 linear beat", 32'(eff_addr), 32'(beat_addr(start, k, 1'b0)));
      if (k >= 4) check("R4 wrap beat", 32'(eff_addr), 32'(beat_addr(start, k - 4, il)));
      check("R5 type kept", 32'(burst_rd), 32'(rd));
      check("R6 upper bits", 32'(eff_addr >> 2), 32'(start >> 2));
    end
  endtask

  task automatic t_stall();
    logic [AW-1:0] start, held;
    start = 17'h0_1235;
    order_il = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 1'b1, start);
    tick();
    drive(1'b1, 1'b0, 1'b0, 1'b1, start);
    tick();
    held = eff_addr;
    for (int i = 0; i < 3; i++) begin
      drive(i[0], ~i[0], 1'b1, 1'b0, 17'h1_FFFC);
      tick();
      check("R8 addr held", 32'(eff_addr), 32'(held));
      check("R8 vld held", 32'(beat_vld), 1);
      check("R8 type held", 32'(burst_rd), 1);
    end
    drive(1'b1, 1'b0, 1'b0, 1'b0, 17'h0);
    tick();
    check("R8 resume beat", 32'(eff_addr), 32'(beat_addr(start, 2, 1'b0)));
  endtask

  task automatic t_deselect();
    drive(1'b0, 1'b1, 1'b0, 1'b0, 17'h0_0402);
    tick();
    drive(1'b1, 1'b1, 1'b0, 1'b0, 17'h0);
    tick();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 17'h0_7777);
    tick();
    check("R7 stop", 32'(beat_vld), 0);
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0);
      tick();
      check("R7 stays stopped", 32'(beat_vld), 0);
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0);
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_burst(17'h0_A5F2, 1'b0, 1'b1);
    t_burst(17'h1_3001, 1'b1, 1'b0);
    t_burst(17'h0_0043, 1'b1, 1'b1);
    t_burst(17'h1_FFFF, 1'b0, 1'b0);
    t_stall();
    t_deselect();
    t_burst(17'h0_0010, 1'b1, 1'b1);
    finish_run();
  end

endmodule